// File: doc/BRIEF.md
# Host-to-DSP Mailbox Status Logic

This block sits on the DSP side of a parallel host port that carries 24-bit words between an external host and a DSP core. It handles the status and handshake flags for both directions. The host writes a word as three bytes (high, middle, low). Once the low byte has landed, the word moves as one unit into a receive register that the DSP can read. The DSP writes a 24-bit transmit word. Once the host has emptied its previous word, that word moves into three host-readable bytes.

The core sees a 16-bit read-only status word. It carries a receive-full flag, a transmit-empty flag, a command-pending flag and two flags mirrored from the host's control bits. The block also drives a gated receive interrupt and a command interrupt. The host can set or withdraw a command bit, and it can force transmit-empty with an initialize strobe. The core acknowledges a command with a one-cycle strobe. All state updates on one clock edge. Reads return data combinationally from the current select.

Top module: `mbox_status`

## Requirements
- R1: After reset: receive-full is 0, transmit-empty is 1, command-pending is 0, receive interrupt enable is 0, host_rxf is 0, and both interrupts are low.
- R2: dsp_rdata with dsp_sel=0 gives the status word. Bit 0 is receive-full, bit 1 transmit-empty, bit 2 command-pending, bits 4:3 host_flags[1:0]. Bits 23:5 read as 0. dsp_sel=2 reads 0, and dsp_sel=3 reads the interrupt enable in bit 0.
- R3: A host write with host_sel=2/1/0 loads the high/middle/low byte. A low-byte write arms a transfer. The armed word moves to the receive register on the first edge after the write at which receive-full is 0, and that edge sets receive-full. dsp_sel=1 reads the receive register.
- R4: A DSP read strobe with dsp_sel=1 clears receive-full at the next edge.
- R5: rx_irq is 1 exactly when the interrupt enable (DSP write, dsp_sel=3, bit 0) and receive-full are both 1.
- R6: A DSP write with dsp_sel=2 loads the transmit word and clears transmit-empty at the next edge. On the following edge, if host_rxf is 0, the word moves to the host bytes. That edge sets host_rxf and transmit-empty. A host read returns low/middle/high for host_sel=0/1/2.
- R7: A host read strobe with host_sel=0 clears host_rxf. A transfer held back by host_rxf=1 proceeds on the edge after the clear.
- R8: host_init forces transmit-empty to 1 and cancels a waiting transfer. It takes priority over a same-cycle DSP transmit write.
- R9: A host write with host_sel=3 loads the command bit from bit 0. Command-pending and cmd_irq equal that bit. host_rdata with host_sel=3 returns it in bit 0. dsp_ack_cmd clears it and wins over a same-cycle host write.
- R10: A host write with host_sel=3 and bit 0 = 0 clears command-pending at the next edge.
- R11: Status bits 4:3 follow host_flags in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_sel | input | 2 | DSP register select |
| dsp_wdata | input | 24 | DSP write data |
| dsp_rdata | output | 24 | DSP read data for dsp_sel |
| dsp_ack_cmd | input | 1 | Core acknowledges the command interrupt |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host byte/register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_sel |
| host_init | input | 1 | Host initialize: force transmit-empty |
| host_flags | input | 2 | Host control flag bits to mirror |
| host_rxf | output | 1 | Host receive bytes hold an unread word |
| rx_irq | output | 1 | Gated receive interrupt request |
| cmd_irq | output | 1 | Command interrupt request |

## Verification
Flag changes caused by a strobe show at the first clock edge after the strobe. Mirrored host flags and read data are combinational and show in the same cycle. A host word takes one extra edge to reach the receive register, and a DSP transmit word likewise takes one extra edge to reach the host bytes. The bench drives each stimulus on the falling edge. It samples read data 1 ns later in that same cycle. It checks flags and interrupts on the next falling edge, against a cycle-stepped model built from the requirements. The two-edge transfers are checked by stepping that model through both edges.

// File: rtl/mbox_status.sv
module mbox_status #(
  parameter int BYTE_W = 8,
  parameter int STAT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dsp_rd,
  input  logic                dsp_wr,
  input  logic [1:0]          dsp_sel,
  input  logic [3*BYTE_W-1:0] dsp_wdata,
  output logic [3*BYTE_W-1:0] dsp_rdata,
  input  logic                dsp_ack_cmd,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [1:0]          host_sel,
  input  logic [BYTE_W-1:0]   host_wdata,
  output logic [BYTE_W-1:0]   host_rdata,
  input  logic                host_init,
  input  logic [1:0]          host_flags,
  output logic                host_rxf,
  output logic                rx_irq,
  output logic                cmd_irq
);
  localparam int WORD_W = 3 * BYTE_W;

  logic [WORD_W-1:0] hold, rx_word, tx_word, host_word;
  logic rxdf, htde, hc, rie, pend, go;

  wire lo_wr   = host_wr && host_sel == 2'd0;
  wire cmd_wr  = host_wr && host_sel == 2'd3;
  wire rx_rd   = dsp_rd && dsp_sel == 2'd1;
  wire tx_wr   = dsp_wr && dsp_sel == 2'd2;
  wire ctl_wr  = dsp_wr && dsp_sel == 2'd3;
  wire hlo_rd  = host_rd && host_sel == 2'd0;
  wire in_move = pend && !rxdf;
  wire out_mv  = go && !host_rxf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0; rx_word <= '0; tx_word <= '0; host_word <= '0;
      rxdf <= 1'b0; htde <= 1'b1; hc <= 1'b0; rie <= 1'b0;
      pend <= 1'b0; go <= 1'b0; host_rxf <= 1'b0;
    end else begin
      if (host_wr && host_sel != 2'd3)
        hold[host_sel*BYTE_W +: BYTE_W] <= host_wdata;
      if (in_move) rx_word <= hold;
      if (lo_wr) pend <= 1'b1;
      else if (in_move) pend <= 1'b0;
      if (in_move) rxdf <= 1'b1;
      else if (rx_rd) rxdf <= 1'b0;

      if (tx_wr) tx_word <= dsp_wdata;
      if (out_mv) host_word <= tx_word;
      if (out_mv) host_rxf <= 1'b1;
      else if (hlo_rd) host_rxf <= 1'b0;

      if (host_init) begin
        htde <= 1'b1; go <= 1'b0;
      end else if (tx_wr) begin
        htde <= 1'b0; go <= 1'b1;
      end else if (out_mv) begin
        htde <= 1'b1; go <= 1'b0;
      end

      if (dsp_ack_cmd) hc <= 1'b0;
      else if (cmd_wr) hc <= host_wdata[0];

      if (ctl_wr) rie <= dsp_wdata[0];
    end
  end

  wire [STAT_W-1:0] status = {{(STAT_W-5){1'b0}}, host_flags, hc, htde, rxdf};

  always_comb begin
    case (dsp_sel)
      2'd0:    dsp_rdata = {{(WORD_W-STAT_W){1'b0}}, status};
      2'd1:    dsp_rdata = rx_word;
      2'd3:    dsp_rdata = {{(WORD_W-1){1'b0}}, rie};
      default: dsp_rdata = '0;
    endcase
    case (host_sel)
      2'd3:    host_rdata = {{(BYTE_W-1){1'b0}}, hc};
      default: host_rdata = host_word[host_sel*BYTE_W +: BYTE_W];
    endcase
  end

  assign rx_irq  = rie && rxdf;
  assign cmd_irq = hc;

  assert_in_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rxdf) |=> (rxdf && rx_word == $past(hold)));
  assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !in_move) |=> !rxdf);
  assert_tx_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !host_init) |=> !htde);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !host_rxf && !host_init && !tx_wr) |=> (htde && host_rxf));
  assert_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_init |=> htde);
  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_ack_cmd |=> !cmd_irq);
  assert_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !host_wdata[0]) |=> !cmd_irq);
endmodule

// File: tb/mbox_status_test.sv
`timescale 1ns/1ps
module mbox_status_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dsp_rd = 0, dsp_wr = 0, dsp_ack_cmd = 0, host_rd = 0, host_wr = 0, host_init = 0;
  logic [1:0] dsp_sel = 0, host_sel = 0, host_flags = 0;
  logic [23:0] dsp_wdata = 0, dsp_rdata;
  logic [7:0] host_wdata = 0, host_rdata;
  logic host_rxf, rx_irq, cmd_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [23:0] m_hold, m_rx, m_tx, m_host;
  bit m_rxdf, m_htde, m_hc, m_rie, m_pend, m_go, m_hrxf;

  always #4 clk = ~clk;

  mbox_status uut (.clk, .rst_n, .dsp_rd, .dsp_wr, .dsp_sel, .dsp_wdata, .dsp_rdata,
    .dsp_ack_cmd, .host_rd, .host_wr, .host_sel, .host_wdata, .host_rdata, .host_init,
    .host_flags, .host_rxf, .rx_irq, .cmd_irq);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] exp_dsp(input logic [1:0] s, input logic [1:0] hf);
    case (s)
      2'd0: return {19'd0, hf, m_hc, m_htde, m_rxdf};
      2'd1: return m_rx;
      2'd3: return {23'd0, m_rie};
      default: return 24'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_host(input logic [1:0] s);
    if (s == 2'd3) return {7'd0, m_hc};
    return m_host[s*8 +: 8];
  endfunction

  task automatic step(input bit drd, input bit dwr, input logic [1:0] ds, input logic [23:0] dwd,
                      input bit hrd, input bit hwr, input logic [1:0] hs, input logic [7:0] hwd,
                      input bit init, input bit ack, input logic [1:0] hf);
    bit inm, outm;
    dsp_rd = drd; dsp_wr = dwr; dsp_sel = ds; dsp_wdata = dwd;
    host_rd = hrd; host_wr = hwr; host_sel = hs; host_wdata = hwd;
    host_init = init; dsp_ack_cmd = ack; host_flags = hf;
    #1;
    if (drd) check(ds == 2'd1 ? "R3 rx word" : "R2 dsp read", dsp_rdata, exp_dsp(ds, hf));
    if (hrd) check(hs == 2'd3 ? "R9 host cmd read" : "R6 host byte", host_rdata, exp_host(hs));
    @(posedge clk);
    inm = m_pend && !m_rxdf;
    outm = m_go && !m_hrxf;
    if (inm) m_rx = m_hold;
    if (hwr && hs != 2'd3) m_hold[hs*8 +: 8] = hwd;
    if (hwr && hs == 2'd0) m_pend = 1; else if (inm) m_pend = 0;
    if (inm) m_rxdf = 1; else if (drd && ds == 2'd1) m_rxdf = 0;
    if (outm) m_host = m_tx;
    if (dwr && ds == 2'd2) m_tx = dwd;
    if (outm) m_hrxf = 1; else if (hrd && hs == 2'd0) m_hrxf = 0;
    if (init) begin m_htde = 1; m_go = 0; end
    else if (dwr && ds == 2'd2) begin m_htde = 0; m_go = 1; end
    else if (outm) begin m_htde = 1; m_go = 0; end
    if (ack) m_hc = 0; else if (hwr && hs == 2'd3) m_hc = hwd[0];
    if (dwr && ds == 2'd3) m_rie = dwd[0];
    @(negedge clk);
    dsp_rd = 0; dsp_wr = 0; host_rd = 0; host_wr = 0; host_init = 0; dsp_ack_cmd = 0;
    dsp_sel = 2'd0;
    #1;
    check("R2 status", dsp_rdata, exp_dsp(2'd0, hf));
    check("R5 rx_irq", rx_irq, m_rie & m_rxdf);
    check("R9 cmd_irq", cmd_irq, m_hc);
    check("R7 host_rxf", host_rxf, m_hrxf);
  endtask

  task automatic idle(input logic [1:0] hf);
    step(0,0,0,0, 0,0,0,0, 0,0, hf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    m_hold = 0; m_rx = 0; m_tx = 0; m_host = 0;
    m_rxdf = 0; m_htde = 1; m_hc = 0; m_rie = 0; m_pend = 0; m_go = 0; m_hrxf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset status", dsp_rdata, 24'h000002);
    check("R1 reset rx_irq", rx_irq, 0);
    check("R1 reset cmd_irq", cmd_irq, 0);
    check("R1 reset host_rxf", host_rxf, 0);
    dsp_sel = 2'd3; #1;
    check("R1 reset enable", dsp_rdata, 0);
    dsp_sel = 2'd0;

    // R3 R4 R5: host word, enable gating, read clears
    step(0,0,0,0, 0,1,2'd2,8'hA1, 0,0, 2'b00);
    step(0,0,0,0, 0,1,2'd1,8'hB2, 0,0, 2'b00);
    step(0,0,0,0, 0,1,2'd0,8'hC3, 0,0, 2'b00);
    check("R3 not yet full", dsp_rdata[0], 0);
    idle(2'b00);
    check("R3 full", dsp_rdata[0], 1);
    check("R5 gated off", rx_irq, 0);
    step(0,1,2'd3,24'd1, 0,0,0,0, 0,0, 2'b00);
    check("R5 irq on", rx_irq, 1);
    step(1,0,2'd1,0, 0,0,0,0, 0,0, 2'b00);
    check("R4 cleared", dsp_rdata[0], 0);
    check("R3 word", m_rx, 24'hA1B2C3);

    // R6 R7: transmit, blocked by unread host bytes
    step(0,1,2'd2,24'h123456, 0,0,0,0, 0,0, 2'b01);
    check("R6 empty cleared", dsp_rdata[1], 0);
    idle(2'b01);
    check("R6 empty set", dsp_rdata[1], 1);
    check("R6 host rxf", host_rxf, 1);
    step(0,1,2'd2,24'h654321, 0,0,0,0, 0,0, 2'b10);
    idle(2'b10);
    check("R7 held", dsp_rdata[1], 0);
    step(0,0,0,0, 1,0,2'd2,0, 0,0, 2'b10);
    step(0,0,0,0, 1,0,2'd0,0, 0,0, 2'b10);
    idle(2'b10);
    check("R7 released", dsp_rdata[1], 1);
    step(0,0,0,0, 1,0,2'd1,0, 0,0, 2'b11);

    // R8: init beats a same-cycle write
    step(0,1,2'd2,24'h0000FF, 0,0,0,0, 1,0, 2'b11);
    check("R8 init", dsp_rdata[1], 1);

    // R9 R10: command set, ack, withdraw, ack priority
    step(0,0,0,0, 0,1,2'd3,8'h01, 0,0, 2'b00);
    check("R9 pending", cmd_irq, 1);
    step(0,0,0,0, 0,0,0,0, 0,1, 2'b00);
    check("R9 ack", cmd_irq, 0);
    step(0,0,0,0, 0,1,2'd3,8'h01, 0,0, 2'b00);
    step(0,0,0,0, 0,1,2'd3,8'h00, 0,0, 2'b00);
    check("R10 withdraw", cmd_irq, 0);
    step(0,0,0,0, 0,1,2'd3,8'h01, 0,1, 2'b00);
    check("R9 ack wins", cmd_irq, 0);

    // R11: mirror in the same cycle
    host_flags = 2'b10; #1;
    check("R11 mirror", dsp_rdata[4:3], 2'b10);
    host_flags = 2'b01; #1;
    check("R11 mirror", dsp_rdata[4:3], 2'b01);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] dop = 3'($urandom % 5);
      logic [2:0] hop = 3'($urandom % 5);
      step(dop == 1, dop >= 2, 2'($urandom), 24'($urandom),
           hop == 1, hop >= 2, 2'($urandom), 8'($urandom),
           ($urandom % 40) == 0, ($urandom % 12) == 0, 2'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule